// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Serial Result Stream

This block is the digital half of a 14-bit successive-approximation converter. When the active-low start input rises, it puts the track/hold into hold. It then walks a binary search over the trial code driven to an external DAC, keeping or clearing one bit per converter-clock rising edge according to a single comparator input. When the search finishes, it latches the result in two's-complement form, releases the hold and pulls an interrupt flag low. A read returns the flag high.

The result is streamed out while the search is still running. The serial port has three open-drain style lines: clock, data and a frame strobe. Each line is modelled as an enable plus a pull-low. The converter clock runs at half the system clock, and the serial clock is that converter clock. A mode input selects whether the serial clock is driven only during the frame or all the time. A second start that arrives mid-conversion is discarded and latches an error flag.

Top module: `sarser_top`

## Requirements
- R1: After reset: int_n is 1, hold is 0, err is 0, result is 0, strb_lo is 0, sdata_oe is 0, and sclk_oe equals sclk_cont.
- R2: A start is detected at the clock edge where start_n is sampled 1 after having been sampled 0 at the previous edge. hold goes to 1 at that edge and stays 1 until end of conversion.
- R3: dac_code is offset binary and equals midscale 0x2000 whenever no conversion is running. cmp = 1 means the input is at or above the trial code. The final result is the search value with its MSB inverted (two's complement), so a comparator threshold T gives result T ^ 0x2000.
- R4: The converter clock is high whenever sclk_lo is 0. A converter rising edge is a clock edge where sclk_lo was 1 before the edge. If the detection edge is itself a converter rising edge, the conversion ends on the 20th such edge, counting that edge as the 1st, which is 38 clocks after detection. Otherwise it ends on the 19th rising edge after detection, which is 37 clocks after detection.
- R5: The frame strobe is driven low (strb_lo = 1) from the detection edge until the edge after the 16th bit. While the strobe is low, sdata_oe is 1. The frame is 16 bits: two 0 bits, then the 14-bit result MSB first. Each bit is read at a falling serial clock edge, and the first leading zero is read at the first falling edge after detection. The data line drives low (sdata_lo = 1) for a 0 bit.
- R6: The data line changes only on converter rising edges, so it is stable across every falling serial clock edge.
- R7: With sclk_cont = 1, sclk_oe is always 1. With sclk_cont = 0, sclk_oe is 1 only from the first bit through the falling edge that reads the 16th bit, and it is 0 whenever no conversion is running.
- R8: int_n goes to 0 at the same edge where hold returns to 0. It stays 0 until rd is sampled 1, and is 1 from the following cycle.
- R9: A start rising edge during a conversion has no effect on timing or result, and it sets err. err stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (twice the converter clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low start pulse; its rising edge starts a conversion |
| cmp | input | 1 | Comparator result for the current trial code |
| rd | input | 1 | Read strobe; returns int_n high |
| sclk_cont | input | 1 | 1 = serial clock driven continuously, 0 = driven only during the frame |
| dac_code | output | 14 | Trial code to the DAC, offset binary |
| hold | output | 1 | Track/hold control, 1 = hold |
| int_n | output | 1 | End-of-conversion flag, active low |
| err | output | 1 | Sticky flag for an illegal start during a conversion |
| result | output | 14 | Last conversion result, two's complement |
| sclk_oe | output | 1 | Serial clock pin enable |
| sclk_lo | output | 1 | Serial clock pull-low (1 = pin low) |
| sdata_oe | output | 1 | Serial data pin enable |
| sdata_lo | output | 1 | Serial data pull-low |
| strb_oe | output | 1 | Frame strobe pin enable |
| strb_lo | output | 1 | Frame strobe pull-low (1 = strobe active) |

## Verification
The bench launches conversions with the start edge placed on each converter-clock phase. A design that mishandles the alignment ends one clock early or late, or drops or duplicates the first leading zero in the captured frame. The thresholds include both extremes, midscale and the code just below it. These expose a search that keeps a bit on the wrong comparator polarity or forgets to invert the MSB. A second start is pulsed partway through a conversion: a design that honours it restarts the search and corrupts both the result and the end time, and one that forgets it leaves err low. The gated-clock mode is checked after the frame, where a design that never releases the clock would keep sclk_oe high.

// File: rtl/sarser_pkg.sv
package sarser_pkg;
   typedef enum logic {
      CODE_OFFSET = 1'b0,
      CODE_TWOS   = 1'b1
   } code_e;
endpackage

// File: rtl/sarser_search.sv
module sarser_search #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         step,
   input  logic         cmp,
   output logic [W-1:0] trial
);
   localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] mask_q;
   logic [W-1:0] b_trial, b_mask, n_trial, n_mask;

   // a launch and a first decision may land on the same edge
   always_comb begin
      b_trial = init ? MID : trial;
      b_mask  = init ? MID : mask_q;
      n_trial = b_trial;
      n_mask  = b_mask;
      if (step && (b_mask != '0)) begin
         n_trial = cmp ? b_trial : (b_trial & ~b_mask);
         n_trial = n_trial | (b_mask >> 1);
         n_mask  = b_mask >> 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial  <= MID;
         mask_q <= '0;
      end else begin
         trial  <= n_trial;
         mask_q <= n_mask;
      end
   end
endmodule

// File: rtl/sarser_frame.sv
module sarser_frame #(
   parameter int W    = 14,
   parameter int LEAD = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         open,
   input  logic         tick,
   input  logic [W-1:0] word,
   output logic         frm,
   output logic         sd,
   output logic         clk_on
);
   localparam int FRAME = LEAD + W;
   localparam int PW    = $clog2(FRAME + 1);
   localparam int IW    = $clog2(W + LEAD);

   logic [PW-1:0] pos_q, b_pos, n_pos;
   logic          b_frm, n_frm, n_sd, n_clk;
   logic [IW-1:0] ix;

   always_comb begin
      b_pos = open ? '0 : pos_q;
      b_frm = open | frm;
      n_pos = b_pos;
      n_frm = b_frm;
      n_sd  = open ? 1'b0 : sd;
      n_clk = open ? 1'b0 : clk_on;
      ix    = IW'(W - 1 + LEAD - int'(b_pos));
      if (tick && b_frm) begin
         if (b_pos < PW'(FRAME)) begin
            n_sd  = (b_pos < PW'(LEAD)) ? 1'b0 : word[ix];
            n_pos = b_pos + 1'b1;
            n_clk = 1'b1;
         end else begin
            n_frm = 1'b0;
            n_sd  = 1'b0;
            n_clk = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         frm    <= 1'b0;
         sd     <= 1'b0;
         clk_on <= 1'b0;
      end else begin
         pos_q  <= n_pos;
         frm    <= n_frm;
         sd     <= n_sd;
         clk_on <= n_clk;
      end
   end
endmodule

// File: rtl/sarser_top.sv
module sarser_top #(
   parameter int                 W      = 14,
   parameter int                 LEAD   = 2,
   parameter int                 EXTRA  = 3,
   parameter sarser_pkg::code_e  CODING = sarser_pkg::CODE_TWOS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_n,
   input  logic         cmp,
   input  logic         rd,
   input  logic         sclk_cont,
   output logic [W-1:0] dac_code,
   output logic         hold,
   output logic         int_n,
   output logic         err,
   output logic [W-1:0] result,
   output logic         sclk_oe,
   output logic         sclk_lo,
   output logic         sdata_oe,
   output logic         sdata_lo,
   output logic         strb_oe,
   output logic         strb_lo
);
   localparam int FRAME     = LEAD + W;
   localparam int END_EARLY = FRAME + EXTRA;
   localparam int END_LATE  = END_EARLY + 1;
   localparam int KW        = $clog2(END_LATE + 1);
   localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

   if (W < 2)     begin : g_bad_w     $error("W must be at least 2");    end
   if (LEAD < 1)  begin : g_bad_lead  $error("LEAD must be at least 1"); end
   if (EXTRA < 1) begin : g_bad_extra $error("EXTRA must be at least 1"); end

   logic          ph, start_q, busy, late, en_q;
   logic [KW-1:0] k, k_inc;
   logic          launch, again, rise, tick, done;
   logic [W-1:0]  trial, coded;
   logic          frm, sd, clk_on;

   assign rise   = ~ph;
   assign launch = ~start_q & start_n & ~busy;
   assign again  = ~start_q & start_n & busy;
   assign tick   = rise & (busy | launch);
   assign k_inc  = k + 1'b1;
   assign done   = busy & rise & (k_inc == (late ? KW'(END_LATE) : KW'(END_EARLY)));

   if (CODING == sarser_pkg::CODE_TWOS) begin : g_twos
      assign coded = {~trial[W-1], trial[W-2:0]};
   end else begin : g_offset
      assign coded = trial;
   end

   sarser_search #(.W(W)) u_search (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (launch),
      .step  (tick),
      .cmp   (cmp),
      .trial (trial)
   );

   sarser_frame #(.W(W), .LEAD(LEAD)) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .open   (launch),
      .tick   (tick),
      .word   (coded),
      .frm    (frm),
      .sd     (sd),
      .clk_on (clk_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= 1'b0;
         start_q <= 1'b1;
         en_q    <= 1'b0;
         busy    <= 1'b0;
         late    <= 1'b0;
         k       <= '0;
         hold    <= 1'b0;
         int_n   <= 1'b1;
         err     <= 1'b0;
         result  <= '0;
      end else begin
         ph      <= ~ph;
         start_q <= start_n;
         en_q    <= 1'b1;
         if (launch) begin
            busy <= 1'b1;
            hold <= 1'b1;
            late <= rise;
            k    <= rise ? KW'(1) : '0;
         end else if (busy && rise) begin
            k <= k_inc;
            if (done) begin
               busy   <= 1'b0;
               hold   <= 1'b0;
               result <= coded;
            end
         end
         if (again) err <= 1'b1;
         if (done)    int_n <= 1'b0;
         else if (rd) int_n <= 1'b1;
      end
   end

   assign dac_code = busy ? trial : MID;
   assign sclk_oe  = sclk_cont | clk_on;
   assign sclk_lo  = ~ph;
   assign sdata_oe = frm;
   assign sdata_lo = ~sd;
   assign strb_oe  = en_q;
   assign strb_lo  = frm;
endmodule

// File: rtl/sarser_chk.sv
module sarser_chk #(
   parameter int W = 14
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_n,
   input logic         rd,
   input logic         sclk_cont,
   input logic [W-1:0] dac_code,
   input logic         hold,
   input logic         int_n,
   input logic         err,
   input logic         sclk_oe,
   input logic         sclk_lo,
   input logic         sdata_lo,
   input logic         strb_lo
);
   localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

   logic sq;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq <= 1'b1;
      else        sq <= start_n;
   end

   AST_START_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (!sq && start_n && !hold) |=> hold);   // R2
   AST_DAC_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !hold |-> (dac_code == MID));         // R3
   AST_FRAME_DONE:  assert property (@(posedge clk) disable iff (!rst_n) $fell(hold) |-> !strb_lo);            // R5
   AST_SDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n) sclk_lo |-> $stable(sdata_lo));     // R6
   AST_GATED_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) (!sclk_cont && !hold) |-> !sclk_oe);  // R7
   AST_EOC_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) $fell(hold) |-> !int_n);            // R8
   AST_RD_CLEAR:    assert property (@(posedge clk) disable iff (!rst_n) (rd && !hold) |=> int_n);             // R8
   AST_ERR_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) err |=> err);                         // R9
endmodule

bind sarser_top sarser_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_n   (start_n),
   .rd        (rd),
   .sclk_cont (sclk_cont),
   .dac_code  (dac_code),
   .hold      (hold),
   .int_n     (int_n),
   .err       (err),
   .sclk_oe   (sclk_oe),
   .sclk_lo   (sclk_lo),
   .sdata_lo  (sdata_lo),
   .strb_lo   (strb_lo)
);

// File: tb/sim_sarser_top.sv
module sim_sarser_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_n = 1'b1;
   logic        rd = 1'b0;
   logic        sclk_cont = 1'b0;
   logic [13:0] tgt = 14'd0;
   logic        cmp;
   logic [13:0] dac_code, result;
   logic        hold, int_n, err, sclk_oe, sclk_lo, sdata_oe, sdata_lo, strb_oe, strb_lo;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   assign cmp = (dac_code <= tgt);

   sarser_top u0 (
      .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmp(cmp), .rd(rd), .sclk_cont(sclk_cont),
      .dac_code(dac_code), .hold(hold), .int_n(int_n), .err(err), .result(result),
      .sclk_oe(sclk_oe), .sclk_lo(sclk_lo), .sdata_oe(sdata_oe), .sdata_lo(sdata_lo),
      .strb_oe(strb_oe), .strb_lo(strb_lo)
   );

   // bit 15: start on a converter rising edge, bit 14: continuous clock, 13:0 threshold
   localparam logic [15:0] VEC [8] = '{
      {1'b0, 1'b0, 14'h0000}, {1'b1, 1'b0, 14'h3FFF},
      {1'b0, 1'b1, 14'h2000}, {1'b1, 1'b1, 14'h1FFF},
      {1'b0, 1'b0, 14'h1555}, {1'b1, 1'b1, 14'h2AAA},
      {1'b0, 1'b1, 14'h0001}, {1'b1, 1'b0, 14'h3FFE}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_conv(input logic [13:0] t, input bit late, input bit cont, input bit twice);
      int m;
      int nb;
      logic [15:0] bits;
      logic [13:0] exp_r;
      bit hold_ok;
      bit fin;
      exp_r = t ^ 14'h2000;
      sclk_cont = cont;
      tgt = t;
      @(negedge clk);
      start_n = 1'b0;
      @(negedge clk);
      while (sclk_lo != late) @(negedge clk);
      start_n = 1'b1;
      @(posedge clk);
      m = 0; nb = 0; bits = '0; hold_ok = 1'b1; fin = 1'b0;
      while (!fin && m < 80) begin
         @(negedge clk);
         if (m == 0) chk(hold == 1'b1, "R2 hold at start", hold, 1);
         if (twice && m == 10) start_n = 1'b0;
         if (twice && m == 12) start_n = 1'b1;
         if (strb_oe && strb_lo && !sclk_lo && sclk_oe) begin
            bits = {bits[14:0], sdata_oe ? ~sdata_lo : 1'b1};
            nb++;
         end
         if (!int_n) fin = 1'b1;
         else begin
            if (!hold) hold_ok = 1'b0;
            m++;
         end
      end
      chk(m == (late ? 38 : 37), "R4 conversion length", m, late ? 38 : 37);
      chk(hold_ok, "R2 hold held through conversion", hold_ok, 1);
      chk(result == exp_r, "R3 result", result, exp_r);
      chk(nb == 16, "R5 frame bit count", nb, 16);
      chk(bits == {2'b00, exp_r}, "R5 frame content", bits, {2'b00, exp_r});
      chk(hold == 1'b0, "R8 hold released at end", hold, 0);
      chk(sclk_oe == cont, "R7 serial clock after frame", sclk_oe, cont);
      repeat (4) @(negedge clk);
      chk(int_n == 1'b0, "R8 flag stays low until read", int_n, 0);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      chk(int_n == 1'b1, "R8 read returns flag high", int_n, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(int_n == 1'b1,   "R1 int_n in reset", int_n, 1);
      chk(hold == 1'b0,    "R1 hold in reset", hold, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(err == 1'b0,     "R1 err after reset", err, 0);
      chk(result == '0,    "R1 result after reset", result, 0);
      chk(strb_lo == 1'b0, "R1 strobe released", strb_lo, 0);
      chk(sdata_oe == 1'b0, "R1 data not driven", sdata_oe, 0);
      chk(sclk_oe == 1'b0, "R7 gated clock idle", sclk_oe, 0);
      chk(dac_code == 14'h2000, "R3 idle dac midscale", dac_code, 14'h2000);
      sclk_cont = 1'b1;
      @(negedge clk);
      chk(sclk_oe == 1'b1, "R7 continuous clock idle", sclk_oe, 1);

      for (int i = 0; i < 8; i++) begin
         do_conv(VEC[i][13:0], VEC[i][15], VEC[i][14], 1'b0);
      end
      chk(err == 1'b0, "R9 no error after legal starts", err, 0);

      do_conv(14'h0A5C, 1'b0, 1'b0, 1'b1);
      chk(err == 1'b1, "R9 error set by second start", err, 1);
      do_conv(14'h3210, 1'b1, 1'b1, 1'b1);
      chk(err == 1'b1, "R9 error stays set", err, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule